// File: doc/BRIEF.md
# Byte-Stream Zero-Free Frame Encoder

This block takes a byte-wide ready/valid stream in which `in_last` ends each frame. It re-codes every frame with consistent overhead byte stuffing, so that the encoded stream carries no 0x00 byte. Zero bytes are removed from the data. Each run of nonzero bytes before a zero becomes a segment: one code byte, equal to the run length plus one, followed by the run itself. A run that reaches 254 bytes is closed straight away with code 0xFF, and no zero is implied after it.

The code byte has to leave before its data. The block therefore holds the open run in a local byte store. While a closed segment is being sent out, the input is stalled. A parameter can add a 0x00 delimiter after every encoded frame, so the frames can be told apart on a link that carries no side-band end marker. Both sides of the block apply backpressure. The user flag that arrives with the last input byte of a frame leaves on the last output beat of that frame.

Top module: `cobs_frame_encoder`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1. The first frame that follows encodes as if no bytes had arrived before the reset.
- R2: A run of n nonzero bytes (n < 254) that a zero byte ends is sent as code byte n+1 followed by the n bytes, in input order. Input zero bytes never appear in the encoded data.
- R3: When a run reaches 254 nonzero bytes, code 0xFF and those 254 bytes are sent at once. No zero is implied, and the next byte starts a new run with its code counting from 1.
- R4: An empty run sends a lone code byte 0x01. This happens for a zero directly after another zero, a zero at the start of a frame, and a zero directly after a 0xFF segment.
- R5: At the end of a frame, the open run is sent as a final segment, and a frame whose last byte is zero ends with an extra lone 0x01. When the last byte completed a 0xFF segment, nothing more is sent.
- R6: With `APPEND_ZERO`=1, one 0x00 byte follows each encoded frame and `out_last` is set on it. With `APPEND_ZERO`=0, `out_last` is set on the final encoded byte. `out_last` is 0 on every other beat.
- R7: The `in_user` value that comes with `in_last` appears as `out_user` on the beat that carries `out_last`. `out_user` is 0 on all other beats.
- R8: `in_ready` is low from the byte that closes a segment until that segment has fully left. While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_last` and `out_user` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Raw frame byte |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts an input byte |
| in_last | input | 1 | Input byte is the last of its frame |
| in_user | input | 1 | Frame flag, sampled with in_last |
| out_data | output | 8 | Encoded byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_last | output | 1 | Final beat of the encoded frame |
| out_user | output | 1 | Frame flag, on the final beat only |

## Verification
The bench aims at the run-length boundaries. It sends runs of 253, 254 and 255 nonzero bytes, and 254 bytes followed by a zero. An off-by-one in the run limit would send a 0xFF segment one byte early or late, or would add or drop the trailing lone 0x01. Frames made only of zeros, and frames that end in a zero, expose a design that forgets the closing empty segment. Random output stalls and input gaps are applied to both delimiter settings. A design that moves the last/user marker, or lets the output change while stalled, is caught beat by beat. A reset in the middle of a frame shows whether stale buffered bytes leak into the next frame.

// File: rtl/cobs_enc_pkg.sv
package cobs_enc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_GATHER = 2'd0,
        ST_HEAD   = 2'd1,
        ST_BODY   = 2'd2,
        ST_DELIM  = 2'd3
    } enc_state_e;

    // what follows once the current segment has left
    typedef enum logic [1:0] {
        TAIL_NONE  = 2'd0,  // more frame data follows
        TAIL_DONE  = 2'd1,  // frame complete after this segment
        TAIL_EMPTY = 2'd2   // frame ended on a zero: lone 0x01 still owed
    } tail_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
        logic              user;
    } beat_t;

    function automatic logic [BYTE_W-1:0] seg_code(input int unsigned len);
        return BYTE_W'(len + 1);
    endfunction

endpackage

// File: rtl/cobs_seg_store.sv
module cobs_seg_store #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cobs_out_reg.sv
module cobs_out_reg
    import cobs_enc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  up_valid,
    input  beat_t up_beat,
    output logic  up_ready,
    output logic  dn_valid,
    output beat_t dn_beat,
    input  logic  dn_ready
);

    logic  vld_q;
    beat_t beat_q;

    assign up_ready = !vld_q || dn_ready;
    assign dn_valid = vld_q;
    assign dn_beat  = beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            beat_q <= '0;
        end else if (up_ready) begin
            vld_q <= up_valid;
            if (up_valid) begin
                beat_q <= up_beat;
            end
        end
    end

    // R8: a stalled beat stays put
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_beat)));

endmodule

// File: rtl/cobs_frame_encoder.sv
module cobs_frame_encoder
    import cobs_enc_pkg::*;
#(
    parameter bit APPEND_ZERO = 1'b0,
    parameter int RUN_MAX     = 254
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_last,
    input  logic       in_user,
    output logic [7:0] out_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_last,
    output logic       out_user
);

    localparam int PTR_W     = $clog2(RUN_MAX + 1);
    localparam int BUF_DEPTH = 1 << PTR_W;
    localparam logic [PTR_W-1:0] RUN_LIM = PTR_W'(RUN_MAX);

    enc_state_e        state_q, state_n;
    tail_e             tail_q, tail_n;
    logic [PTR_W-1:0]  cnt_q, cnt_n;
    logic [PTR_W-1:0]  rd_q, rd_n;
    logic [BYTE_W-1:0] code_q, code_n;
    logic              user_q, user_n;

    logic              wr_en;
    logic [BYTE_W-1:0] rd_byte;
    logic              st_valid, st_ready;
    beat_t             st_beat, o_beat;
    logic              is_final;
    logic              take;

    cobs_seg_store #(
        .DEPTH  (BUF_DEPTH),
        .ADDR_W (PTR_W),
        .DATA_W (BYTE_W)
    ) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (cnt_q),
        .wr_data (in_data),
        .rd_addr (rd_q),
        .rd_data (rd_byte)
    );

    cobs_out_reg oreg_i (
        .clk      (clk),
        .rst      (rst),
        .up_valid (st_valid),
        .up_beat  (st_beat),
        .up_ready (st_ready),
        .dn_valid (out_valid),
        .dn_beat  (o_beat),
        .dn_ready (out_ready)
    );

    assign out_data = o_beat.data;
    assign out_last = o_beat.last;
    assign out_user = o_beat.user;

    assign in_ready = (state_q == ST_GATHER);
    assign take     = in_valid && in_ready;
    assign wr_en    = take && (in_data != '0);
    assign st_valid = (state_q != ST_GATHER);

    // a segment that is the frame's last encoded output
    generate
        if (APPEND_ZERO) begin : g_delim
            assign is_final = 1'b0;
        end else begin : g_nodelim
            assign is_final = (tail_q == TAIL_DONE);
        end
    endgenerate

    always_comb begin
        st_beat = '0;
        unique case (state_q)
            ST_HEAD: begin
                st_beat.data = code_q;
                st_beat.last = is_final && (cnt_q == '0);
            end
            ST_BODY: begin
                st_beat.data = rd_byte;
                st_beat.last = is_final && (rd_q == cnt_q - 1'b1);
            end
            ST_DELIM: begin
                st_beat.data = '0;
                st_beat.last = 1'b1;
            end
            default: st_beat = '0;
        endcase
        st_beat.user = st_beat.last && user_q;
    end

    always_comb begin
        state_n = state_q;
        tail_n  = tail_q;
        cnt_n   = cnt_q;
        rd_n    = rd_q;
        code_n  = code_q;
        user_n  = user_q;
        unique case (state_q)
            ST_GATHER: begin
                if (take) begin
                    if (in_last) begin
                        user_n = in_user;
                    end
                    rd_n = '0;
                    if (in_data != '0) begin
                        cnt_n = cnt_q + 1'b1;
                        if (cnt_q + 1'b1 == RUN_LIM) begin
                            code_n  = seg_code(RUN_MAX);
                            tail_n  = in_last ? TAIL_DONE : TAIL_NONE;
                            state_n = ST_HEAD;
                        end else if (in_last) begin
                            code_n  = seg_code(int'(cnt_q) + 1);
                            tail_n  = TAIL_DONE;
                            state_n = ST_HEAD;
                        end
                    end else begin
                        code_n  = seg_code(int'(cnt_q));
                        tail_n  = in_last ? TAIL_EMPTY : TAIL_NONE;
                        state_n = ST_HEAD;
                    end
                end
            end
            ST_HEAD, ST_BODY: begin
                if (st_ready) begin
                    if (state_q == ST_HEAD && cnt_q != '0) begin
                        state_n = ST_BODY;
                    end else if (state_q == ST_BODY && rd_q != cnt_q - 1'b1) begin
                        rd_n = rd_q + 1'b1;
                    end else begin
                        // segment fully sent
                        cnt_n = '0;
                        rd_n  = '0;
                        unique case (tail_q)
                            TAIL_EMPTY: begin
                                code_n  = seg_code(0);
                                tail_n  = TAIL_DONE;
                                state_n = ST_HEAD;
                            end
                            TAIL_DONE: begin
                                tail_n  = TAIL_NONE;
                                state_n = APPEND_ZERO ? ST_DELIM : ST_GATHER;
                            end
                            default: state_n = ST_GATHER;
                        endcase
                    end
                end
            end
            ST_DELIM: begin
                if (st_ready) begin
                    state_n = ST_GATHER;
                end
            end
            default: state_n = ST_GATHER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_GATHER;
            tail_q  <= TAIL_NONE;
            cnt_q   <= '0;
            rd_q    <= '0;
            code_q  <= '0;
            user_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            tail_q  <= tail_n;
            cnt_q   <= cnt_n;
            rd_q    <= rd_n;
            code_q  <= code_n;
            user_q  <= user_n;
        end
    end

    // R1: output empty straight after reset
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

    // R2: a zero on the output is only ever the delimiter
    assert_no_zero_out_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_data == '0) |-> (APPEND_ZERO && out_last));

    // R3: the run store never exceeds its limit while gathering
    assert_run_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GATHER) |-> (cnt_q < RUN_LIM));

    // R7: user flag only on the frame's final beat
    assert_user_on_last_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_user) |-> out_last);

    // R8: input held off while a segment drains
    assert_ready_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (take && in_data == '0) |=> !in_ready);

endmodule

// File: tb/cobs_frame_encoder_tb_top.sv
`timescale 1ns / 1ps
module cobs_frame_encoder_tb_top;

    typedef logic [7:0] bq_t[$];
    typedef logic [9:0] wq_t[$];   // {user, last, data}

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_user = 1'b0;
    logic       out_ready = 1'b1;
    int         sel = 0;
    bit         bp_on = 1'b0;
    bit         gap_on = 1'b0;

    logic       rdy0, rdy1, ov0, ov1, ol0, ol1, ou0, ou1;
    logic [7:0] od0, od1;

    cobs_frame_encoder #(.APPEND_ZERO(1'b0)) dut_i (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_valid(in_valid && sel == 0), .in_ready(rdy0),
        .in_last(in_last), .in_user(in_user),
        .out_data(od0), .out_valid(ov0), .out_ready(out_ready),
        .out_last(ol0), .out_user(ou0)
    );

    cobs_frame_encoder #(.APPEND_ZERO(1'b1)) dut_delim_i (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_valid(in_valid && sel == 1), .in_ready(rdy1),
        .in_last(in_last), .in_user(in_user),
        .out_data(od1), .out_valid(ov1), .out_ready(out_ready),
        .out_last(ol1), .out_user(ou1)
    );

    wire       m_rdy  = sel ? rdy1 : rdy0;
    wire       m_vld  = sel ? ov1 : ov0;
    wire [9:0] m_word = sel ? {ou1, ol1, od1} : {ou0, ol0, od0};

    int  n_chk = 0;
    int  n_fail = 0;
    wq_t got_q;
    wq_t exp_q;
    logic       stall_prev = 1'b0;
    logic [9:0] word_prev = '0;
    int         cyc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // consumer: picks ready, records handshakes, checks stall hold (R8)
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            stall_prev = 1'b0;
            out_ready  = 1'b1;
        end else begin
            if (stall_prev) begin
                check(m_vld && m_word == word_prev, "R8", "stalled beat changed",
                      {m_vld, m_word}, {1'b1, word_prev});
            end
            out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
            if (m_vld && out_ready) got_q.push_back(m_word);
            stall_prev = m_vld && !out_ready;
            word_prev  = m_word;
        end
    end

    // watchdog
    initial begin
        wait (cyc > 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // bench-side reference encoder
    task automatic build_exp(input bq_t src, input logic usr, input bit delim);
        bq_t seg;
        bit  just_full = 1'b0;
        exp_q.delete();
        seg.delete();
        foreach (src[i]) begin
            just_full = 1'b0;
            if (src[i] == 8'h00) begin
                exp_q.push_back({2'b00, 8'(seg.size() + 1)});
                foreach (seg[j]) exp_q.push_back({2'b00, seg[j]});
                seg.delete();
            end else begin
                seg.push_back(src[i]);
                if (seg.size() == 254) begin
                    exp_q.push_back({2'b00, 8'hFF});
                    foreach (seg[j]) exp_q.push_back({2'b00, seg[j]});
                    seg.delete();
                    just_full = 1'b1;
                end
            end
        end
        if (!just_full) begin
            exp_q.push_back({2'b00, 8'(seg.size() + 1)});
            foreach (seg[j]) exp_q.push_back({2'b00, seg[j]});
        end
        if (delim) exp_q.push_back({2'b00, 8'h00});
        exp_q[exp_q.size() - 1][9:8] = {usr, 1'b1};
    endtask

    task automatic drive_frame(input bq_t src, input logic usr, input bit stop_early);
        foreach (src[i]) begin
            if (gap_on && ($urandom % 4 == 0)) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = src[i];
            in_last  = !stop_early && (i == src.size() - 1);
            in_user  = in_last ? usr : 1'b0;
            while (!m_rdy) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_user  = 1'b0;
    endtask

    task automatic run_frame(input bq_t src, input logic usr, input string req);
        int mism;
        build_exp(src, usr, sel == 1);
        got_q.delete();
        drive_frame(src, usr, 1'b0);
        for (int k = 0; k < 4000 && got_q.size() < exp_q.size(); k++) @(negedge clk);
        repeat (8) @(negedge clk);
        check(got_q.size() == exp_q.size(), req, "encoded length", got_q.size(), exp_q.size());
        mism = -1;
        foreach (exp_q[i]) begin
            if (mism < 0 && (i >= got_q.size() || got_q[i] !== exp_q[i])) mism = i;
        end
        if (mism >= 0) begin
            check(1'b0, req, $sformatf("beat %0d {user,last,data}", mism),
                  (mism < got_q.size()) ? got_q[mism] : -1, exp_q[mism]);
        end else begin
            check(1'b1, req, "beats", 0, 0);
        end
    endtask

    function automatic bq_t ramp(input int n, input int start);
        bq_t q;
        for (int i = 0; i < n; i++) q.push_back(8'((start + i) % 255 + 1));
        return q;
    endfunction

    // scenario tasks
    task automatic t_reset_state();
        check(!ov0 && !ov1, "R1", "out_valid after reset", {ov1, ov0}, 0);
        check(rdy0 && rdy1, "R1", "in_ready after reset", {rdy1, rdy0}, 3);
    endtask

    task automatic t_basic(); // R2, R5
        run_frame('{8'h11, 8'h22, 8'h33}, 1'b0, "R5");
        run_frame('{8'h11, 8'h00, 8'h22}, 1'b0, "R2");
        run_frame('{8'h05, 8'h00, 8'h07, 8'h08, 8'h00, 8'h09}, 1'b0, "R2");
        run_frame('{8'h42}, 1'b0, "R5");
    endtask

    task automatic t_empty(); // R4, R5
        run_frame('{8'h00}, 1'b0, "R4");
        run_frame('{8'h00, 8'h00, 8'h00}, 1'b0, "R4");
        run_frame('{8'h00, 8'h31, 8'h00}, 1'b0, "R5");
    endtask

    task automatic t_long(); // R3, R4, R5
        bq_t q;
        run_frame(ramp(253, 0), 1'b0, "R3");
        run_frame(ramp(254, 3), 1'b0, "R3");
        run_frame(ramp(255, 7), 1'b0, "R3");
        q = ramp(254, 1);
        q.push_back(8'h00);
        run_frame(q, 1'b0, "R4");
        q = ramp(254, 9);
        q.push_back(8'h00);
        q.push_back(8'h5A);
        run_frame(q, 1'b0, "R3");
        run_frame(ramp(600, 2), 1'b0, "R3");
    endtask

    task automatic t_user(); // R7, R6
        run_frame('{8'h01, 8'h02}, 1'b1, "R7");
        run_frame('{8'h00}, 1'b1, "R7");
        run_frame(ramp(254, 4), 1'b1, "R7");
        run_frame('{8'h10, 8'h00, 8'h20}, 1'b0, "R6");
    endtask

    task automatic t_pressure(); // R8
        bq_t q;
        bp_on  = 1'b1;
        gap_on = 1'b1;
        q = ramp(300, 5);
        q[40] = 8'h00;
        q[41] = 8'h00;
        run_frame(q, 1'b1, "R8");
        run_frame('{8'h00, 8'h00, 8'h77, 8'h00}, 1'b0, "R8");
        bp_on  = 1'b0;
        gap_on = 1'b0;
    endtask

    task automatic t_mid_reset(); // R1
        drive_frame('{8'hAA, 8'hBB, 8'hCC}, 1'b0, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!m_vld, "R1", "out_valid after mid-frame reset", m_vld, 0);
        check(m_rdy, "R1", "in_ready after mid-frame reset", m_rdy, 1);
        run_frame('{8'h0D, 8'h0E}, 1'b0, "R1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        for (int s = 0; s < 2; s++) begin
            sel = s;
            t_basic();
            t_empty();
            t_long();
            t_user();
            t_pressure();
            t_mid_reset();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule